// File: doc/BRIEF.md
# Melody Tone Sequencer

This block turns a fast reference clock into a square wave that plays a short tune which is fixed when the block is built. Inside is a programmable divider. It produces an output period equal to the current divisor, counted in reference clocks. A small controller walks the divider through eleven divisors in a fixed order. It holds each divisor for a set number of complete output periods, then moves to the next one.

Playback runs only while the enable input is high. Dropping enable freezes the tune mid-note: the output keeps its level and no count moves. After the final note the output rests low and a done flag rises. From then on only the active-low synchronous reset starts the tune again from its first note.

Top module: `melody_tone_top`

## Requirements
- R1: While `rstN` is low at a clock edge, the next state has `toneOut` low and `playDone` low, the divide count and repetition count cleared, and the note pointer on the first note. Playback after release begins with the first note.
- R2: With enable high, the output starts low. It rises after divisor/2 enabled clocks and falls after a further divisor/2, so one output period equals the divisor in enabled clocks.
- R3: The divisors used, in order, are 956, 852, 758, 758, 852, 956, 956, 852, 758, 852, 956.
- R4: A period ends on a falling transition of `toneOut`. Each note lasts exactly `REPS` complete periods (default 50) before the next divisor takes over.
- R5: When the note changes, the divide count starts again from zero, so the first period of the new note equals the new divisor exactly.
- R6: A clock edge with `playEn` low changes neither `toneOut` nor `playDone`, and it is not counted toward any half-period or repetition.
- R7: `playDone` rises on the same edge as the falling transition that ends the last period of the last note. After that `toneOut` stays low and `playDone` stays high whatever `playEn` does, until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| playEn | input | 1 | High lets the tune advance; low pauses it |
| toneOut | output | 1 | Square-wave tone |
| playDone | output | 1 | High once the last note has finished |

## Verification
Two things can fall on one clock edge: the divider's falling toggle that ends a period and the controller's step to the next note, or to done after the last note. The bench plays the whole tune with a short repetition count. It times every half-period and every period at the port against the divisor it expects for that period index, so any off-by-one at a note boundary shows up as a wrong length in the first period of the new note. A repeating pause pattern drops enable at moments that drift across those boundaries. The bench checks that paused edges move nothing and are not counted.

// File: rtl/melody_pkg.sv
package melody_pkg;

  localparam int DIV_W      = 10;
  localparam int NOTE_COUNT = 11;
  localparam int IDX_W      = $clog2(NOTE_COUNT);

  // control-to-datapath strobes
  typedef struct packed {
    logic run;   // advance the divide count on this edge
    logic mute;  // force silence and clear the divider
  } ctrlStrobe_t;

  function automatic logic [DIV_W-1:0] noteDivisor(input logic [IDX_W-1:0] idx);
    logic [DIV_W-1:0] d;
    case (idx)
      4'd0:    d = DIV_W'(956);
      4'd1:    d = DIV_W'(852);
      4'd2:    d = DIV_W'(758);
      4'd3:    d = DIV_W'(758);
      4'd4:    d = DIV_W'(852);
      4'd5:    d = DIV_W'(956);
      4'd6:    d = DIV_W'(956);
      4'd7:    d = DIV_W'(852);
      4'd8:    d = DIV_W'(758);
      4'd9:    d = DIV_W'(852);
      default: d = DIV_W'(956);
    endcase
    return d;
  endfunction

endpackage

// File: rtl/tone_divider.sv
module tone_divider
  import melody_pkg::*;
#(
  parameter int W = DIV_W
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strobes,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] divCnt,
  output logic        toneOut,
  output logic        periodEnd
);

  logic [W-1:0] halfLast;
  logic         halfHit;

  always_comb begin
    halfLast  = (divisor >> 1) - W'(1);
    halfHit   = strobes.run && (divCnt == halfLast);
    periodEnd = halfHit && toneOut;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobes.mute) begin
      divCnt  <= '0;
      toneOut <= 1'b0;
    end else if (strobes.run) begin
      if (halfHit) begin
        divCnt  <= '0;
        toneOut <= ~toneOut;
      end else begin
        divCnt <= divCnt + W'(1);
      end
    end
  end

endmodule

// File: rtl/note_sequencer.sv
module note_sequencer
  import melody_pkg::*;
#(
  parameter int REPS  = 50,
  parameter int REP_W = (REPS > 1) ? $clog2(REPS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             playEn,
  input  logic             periodEnd,
  output ctrlStrobe_t      strobes,
  output logic [DIV_W-1:0] divisor,
  output logic [IDX_W-1:0] noteIdx,
  output logic [REP_W-1:0] repCnt,
  output logic             playDone
);

  logic lastRep, lastNote;

  always_comb begin
    strobes.run  = playEn && !playDone;
    strobes.mute = playDone;
    divisor      = noteDivisor(noteIdx);
    lastRep      = (repCnt == REP_W'(REPS - 1));
    lastNote     = (noteIdx == IDX_W'(NOTE_COUNT - 1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      noteIdx  <= '0;
      repCnt   <= '0;
      playDone <= 1'b0;
    end else if (periodEnd) begin
      if (lastRep) begin
        repCnt <= '0;
        if (lastNote) playDone <= 1'b1;
        else          noteIdx  <= noteIdx + IDX_W'(1);
      end else begin
        repCnt <= repCnt + REP_W'(1);
      end
    end
  end

endmodule

// File: rtl/melody_tone_top.sv
module melody_tone_top
  import melody_pkg::*;
#(
  parameter int REPS = 50
) (
  input  logic clk,
  input  logic rstN,
  input  logic playEn,
  output logic toneOut,
  output logic playDone
);

  localparam int REP_W = (REPS > 1) ? $clog2(REPS) : 1;

  ctrlStrobe_t      strobes;
  logic [DIV_W-1:0] divisor;
  logic [DIV_W-1:0] divCnt;
  logic [IDX_W-1:0] noteIdx;
  logic [REP_W-1:0] repCnt;
  logic             periodEnd;

  note_sequencer #(.REPS(REPS), .REP_W(REP_W)) u_seq (
    .clk(clk), .rstN(rstN), .playEn(playEn), .periodEnd(periodEnd),
    .strobes(strobes), .divisor(divisor), .noteIdx(noteIdx),
    .repCnt(repCnt), .playDone(playDone)
  );

  tone_divider #(.W(DIV_W)) u_div (
    .clk(clk), .rstN(rstN), .strobes(strobes), .divisor(divisor),
    .divCnt(divCnt), .toneOut(toneOut), .periodEnd(periodEnd)
  );

endmodule

// File: rtl/melody_tone_checker.sv
module melody_tone_checker
  import melody_pkg::*;
#(
  parameter int REPS  = 50,
  parameter int REP_W = (REPS > 1) ? $clog2(REPS) : 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             playEn,
  input logic             toneOut,
  input logic             playDone,
  input logic [IDX_W-1:0] noteIdx,
  input logic [REP_W-1:0] repCnt,
  input logic [DIV_W-1:0] divCnt,
  input logic [DIV_W-1:0] divisor,
  input logic             periodEnd
);

  p_reset_state_r1: assert property (@(posedge clk)
    !rstN |=> (!toneOut && !playDone && noteIdx == '0 && repCnt == '0));

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    divCnt < (divisor >> 1));

  p_note_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && noteIdx != $past(noteIdx))
      |-> (noteIdx == $past(noteIdx) + IDX_W'(1)) && $past(periodEnd));

  p_rep_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    repCnt < REP_W'(REPS) || REPS == 1);

  p_period_falls_r4: assert property (@(posedge clk) disable iff (!rstN)
    periodEnd |=> !toneOut);

  p_restart_r5: assert property (@(posedge clk) disable iff (!rstN)
    periodEnd |=> divCnt == '0);

  p_pause_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !playEn |=> $stable(toneOut) && $stable(playDone));

  p_done_silent_r7: assert property (@(posedge clk) disable iff (!rstN)
    playDone |-> !toneOut);

  p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    playDone |=> playDone);

endmodule

bind melody_tone_top melody_tone_checker #(.REPS(REPS), .REP_W(REP_W)) u_chk (
  .clk(clk), .rstN(rstN), .playEn(playEn), .toneOut(toneOut),
  .playDone(playDone), .noteIdx(noteIdx), .repCnt(repCnt),
  .divCnt(divCnt), .divisor(divisor), .periodEnd(periodEnd)
);

// File: tb/tb_melody_tone_top.sv
`timescale 1ns/1ps
module tb_melody_tone_top;

  localparam int REPS_TB = 3;
  localparam int NOTES   = 11;
  localparam int TOTAL   = NOTES * REPS_TB;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic playEn = 1'b0;
  logic toneOut, playDone;

  always #2 clk = ~clk;

  melody_tone_top #(.REPS(REPS_TB)) dut (
    .clk(clk), .rstN(rstN), .playEn(playEn),
    .toneOut(toneOut), .playDone(playDone)
  );

  int tune [NOTES] = '{956, 852, 758, 758, 852, 956, 956, 852, 758, 852, 956};

  int  checks = 0;
  int  fails  = 0;
  int  activeCnt = 0;
  int  perIdx = 0;
  int  cyc = 0;
  logic enApplied = 1'b0;
  logic lastTone = 1'b0;
  logic lastDone = 1'b0;

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (period %0d)", req, act, exp, perIdx);
    end
  endtask

  function automatic int expDiv(input int p);
    return (p < TOTAL) ? tune[p / REPS_TB] : 0;
  endfunction

  // one clock: sample after the edge, judge, then set enable for the next edge
  task automatic step(input logic nextEn);
    @(negedge clk);
    cyc++;
    if (enApplied) activeCnt++;
    else begin
      check(toneOut == lastTone, "R6 tone held while paused", int'(toneOut), int'(lastTone));
      check(playDone == lastDone, "R6 done held while paused", int'(playDone), int'(lastDone));
    end
    if (toneOut && !lastTone)
      check(activeCnt == expDiv(perIdx) / 2, "R2 high after half divisor", activeCnt, expDiv(perIdx) / 2);
    if (!toneOut && lastTone) begin
      // R3 R4 R5: full period equals the divisor for this period index
      check(activeCnt == expDiv(perIdx), "R3/R4/R5 period length", activeCnt, expDiv(perIdx));
      activeCnt = 0;
      perIdx++;
      check(playDone == (perIdx >= TOTAL), "R7 done at last fall", int'(playDone), int'(perIdx >= TOTAL));
    end
    if (perIdx >= TOTAL) begin
      check(playDone == 1'b1, "R7 done stays high", int'(playDone), 1);
      check(toneOut == 1'b0, "R7 silent after tune", int'(toneOut), 0);
    end
    lastTone  = toneOut;
    lastDone  = playDone;
    playEn    = nextEn;
    enApplied = nextEn;
  endtask

  task automatic doReset();
    playEn = 1'b0;
    rstN   = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(toneOut == 1'b0, "R1 tone low in reset", int'(toneOut), 0);
    check(playDone == 1'b0, "R1 done low in reset", int'(playDone), 0);
    rstN = 1'b1;
    activeCnt = 0; perIdx = 0; enApplied = 1'b0;
    lastTone = 1'b0; lastDone = 1'b0;
  endtask

  initial begin
    doReset();
    // R1: reset in the middle of note 1 while the output is high
    while (perIdx < REPS_TB + 1) step(1'b1);
    while (!toneOut) step(1'b1);
    doReset();
    // full tune with recurring pauses (R6), restart from note 0 checks R1
    while (perIdx < TOTAL) step(!((cyc % 211) < 7));
    // R7: enable toggling after the end has no effect
    for (int i = 0; i < 1500; i++) step(i[3]);
    check(playDone == 1'b1, "R7 done held to reset", int'(playDone), 1);
    // R1: reset after done restarts the tune
    doReset();
    while (perIdx < 2) step(1'b1);
    check(playDone == 1'b0, "R1 playing after restart", int'(playDone), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule